// File: doc/BRIEF.md
# Arithmetic and logic opcode classifier

This block looks at the first 16-bit word of an instruction and decides whether it belongs to the register and memory add, subtract, and, or and exclusive-or families, or to the immediate or, subtract and exclusive-or forms. For each word it reports which operation applies, the operand size, which way the data moves, the register number, and the raw addressing-mode and mode-register fields. It raises an illegal flag when the word falls outside these families or uses an addressing mode that the operation does not allow.

Classification is purely combinational. The result is captured in an output register. A word is offered with `in_valid`. Once reset is released, `in_ready` stays high, so one word can be accepted every cycle. The result of an accepted word appears, with `out_valid` high, on the cycle after it is accepted. Extension-word fetch, address arithmetic and execution belong to other blocks.

Top module: `alu_opc_decoder`

## Requirements
- R1: During reset `in_ready` and `out_valid` are 0, `out_op` is 0 and `out_illegal` is 0. After reset `in_ready` is 1. A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 in the cycle after an accepted word and 0 after a cycle with no accepted word.
- R2: Bits 15:12 pick the family. 1101 is add, 1001 is subtract, 1100 is and, 1000 is or, and 1011 with bit 8 set is exclusive-or. The operation codes are NONE=0, ADD=1, SUB=2, AND=3, OR=4, EOR=5, ADDA=6, SUBA=7, SUBX=8, ORI=9, SUBI=10, EORI=11.
- R3: For a legal register or memory form, `out_reg` is bits 11:9, `out_dir` is bit 8 (0 means the effective address is the source, 1 means it is the destination), `out_size` is bits 7:6 (0 byte, 1 word, 2 long), `out_mode` is bits 5:3 and `out_mreg` is bits 2:0.
- R4: When the effective address is the source (bit 8 = 0), mode 7 with a mode register of 5, 6 or 7 is illegal.
- R5: When the effective address is the destination (bit 8 = 1), modes 0 and 1 are illegal, and so is mode 7 with a mode register of 2 or more. Exclusive-or is the exception: it accepts mode 0.
- R6: A byte-size add or subtract whose source is an address register (mode 1, bit 8 = 0) is illegal. For and and or with bit 8 = 0, mode 1 is illegal at every size.
- R7: Size field 11 in the add or subtract family gives ADDA or SUBA. In that case `out_size` is 1 when bit 8 = 0 and 2 when bit 8 = 1, `out_dir` is 0, `out_reg` is bits 11:9, and the source rule of R4 applies.
- R8: Bits 15:8 equal to 0x00 give ORI, 0x04 give SUBI and 0x0A give EORI, with the size in bits 7:6. Size 11 is illegal. Mode 1 is illegal, and so is mode 7 with a mode register of 2 or more. For these forms `out_dir` is 1 and `out_reg` is 0.
- R9: A subtract-family word with bit 8 = 1, size other than 11 and bits 5:4 = 00 is SUBX. Bit 3 = 0 means data register to data register, and bit 3 = 1 means pre-decrement to pre-decrement. `out_reg` is the target (bits 11:9), `out_mreg` is the source (bits 2:0), and `out_mode` carries bits 5:3 unchanged.
- R10: A word that matches none of the forms above, or that breaks a mode rule, gives `out_illegal` = 1 and `out_op` = NONE. The and, or and exclusive-or families with size 11 are illegal.
- R11: In a cycle with no accepted word, every result output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction word is offered |
| in_ready | output | 1 | The block can take a word |
| in_word | input | 16 | First instruction word |
| out_valid | output | 1 | The result outputs hold a fresh classification |
| out_op | output | 4 | Operation code (R2) |
| out_size | output | 2 | Operand size: 0 byte, 1 word, 2 long |
| out_dir | output | 1 | 0: effective address is the source; 1: effective address is the destination |
| out_reg | output | 3 | Data or address register number |
| out_mode | output | 3 | Addressing-mode field |
| out_mreg | output | 3 | Mode-register field |
| out_illegal | output | 1 | The word is outside the families or uses a disallowed mode |

## Verification
The assertions expect `in_valid` to be known and `in_word` to be fully known whenever a word is accepted. They check register-level relations that follow from the legality rules, so they need no reference model. The stimulus drives only two-state values, changes inputs on the falling edge, and inserts idle cycles only by lowering `in_valid`. As a result, every accepted word is well formed, even when its encoding is illegal. The whole 65,536-word space is swept back to back after the directed and random phases, so every legality boundary is reached.

// File: rtl/alu_opc_pkg.sv
package alu_opc_pkg;
  localparam int WORD_W  = 16;
  localparam int OP_W    = 4;
  localparam int FIELD_W = 3;
  localparam int SIZE_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_AND = 4'd3,
    OP_OR   = 4'd4,  OP_EOR  = 4'd5,  OP_ADDA = 4'd6,  OP_SUBA = 4'd7,
    OP_SUBX = 4'd8,  OP_ORI  = 4'd9,  OP_SUBI = 4'd10, OP_EORI = 4'd11
  } op_e;

  typedef enum logic [2:0] {
    GRP_NONE, GRP_ADDSUB, GRP_ANDOR, GRP_EOR, GRP_IMM
  } grp_e;

  typedef struct packed {
    logic                illegal;
    op_e                 op;
    logic [SIZE_W-1:0]   size;
    logic                dir;
    logic [FIELD_W-1:0]  rnum;
    logic [FIELD_W-1:0]  mode;
    logic [FIELD_W-1:0]  mreg;
  } dec_t;

  // Mode 7 sub-cases: the mode-register field at or above a limit is unusable.
  function automatic logic m7_at_or_above(input logic [FIELD_W-1:0] mode,
                                          input logic [FIELD_W-1:0] mreg,
                                          input logic [FIELD_W-1:0] limit);
    return (mode == 3'd7) && (mreg >= limit);
  endfunction
endpackage

// File: rtl/alu_opc_group.sv
module alu_opc_group
  import alu_opc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output grp_e              grp,
  output logic              is_sub,
  output logic              is_or,
  output op_e               imm_op
);
  logic [3:0] hi_nib;
  logic [3:0] sub_nib;
  assign hi_nib  = word[15:12];
  assign sub_nib = word[11:8];

  always_comb begin
    grp    = GRP_NONE;
    is_sub = (hi_nib == 4'b1001);
    is_or  = (hi_nib == 4'b1000);
    imm_op = OP_NONE;
    unique case (hi_nib)
      4'b1101, 4'b1001: grp = GRP_ADDSUB;
      4'b1100, 4'b1000: grp = GRP_ANDOR;
      4'b1011:          grp = word[8] ? GRP_EOR : GRP_NONE;
      4'b0000: begin
        unique case (sub_nib)
          4'b0000: begin grp = GRP_IMM; imm_op = OP_ORI;  end
          4'b0100: begin grp = GRP_IMM; imm_op = OP_SUBI; end
          4'b1010: begin grp = GRP_IMM; imm_op = OP_EORI; end
          default: grp = GRP_NONE;
        endcase
      end
      default: grp = GRP_NONE;
    endcase
  end
endmodule

// File: rtl/alu_opc_ea_rules.sv
module alu_opc_ea_rules
  import alu_opc_pkg::*;
(
  input  logic [FIELD_W-1:0] mode,
  input  logic [FIELD_W-1:0] mreg,
  output logic               src_any_ok,   // any register or memory source
  output logic               src_noar_ok,  // source, address register excluded
  output logic               dst_mem_ok,   // alterable memory destination only
  output logic               dst_dat_ok    // data register or alterable memory
);
  logic src_hi;
  logic dst_hi;
  assign src_hi      = m7_at_or_above(mode, mreg, 3'd5);
  assign dst_hi      = m7_at_or_above(mode, mreg, 3'd2);
  assign src_any_ok  = !src_hi;
  assign src_noar_ok = !src_hi && (mode != 3'd1);
  assign dst_mem_ok  = !dst_hi && (mode > 3'd1);
  assign dst_dat_ok  = !dst_hi && (mode != 3'd1);
endmodule

// File: rtl/alu_opc_core.sv
module alu_opc_core
  import alu_opc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  grp_e grp;
  logic is_sub, is_or;
  op_e  imm_op;
  logic src_any_ok, src_noar_ok, dst_mem_ok, dst_dat_ok;

  alu_opc_group u_group (
    .word(word), .grp(grp), .is_sub(is_sub), .is_or(is_or), .imm_op(imm_op)
  );

  alu_opc_ea_rules u_rules (
    .mode(word[5:3]), .mreg(word[2:0]),
    .src_any_ok(src_any_ok), .src_noar_ok(src_noar_ok),
    .dst_mem_ok(dst_mem_ok), .dst_dat_ok(dst_dat_ok)
  );

  logic [SIZE_W-1:0] sz;
  logic              dbit;
  assign sz   = word[7:6];
  assign dbit = word[8];

  op_e  cand;
  logic ok;

  always_comb begin
    dec      = '0;
    dec.size = sz;
    dec.dir  = dbit;
    dec.rnum = word[11:9];
    dec.mode = word[5:3];
    dec.mreg = word[2:0];
    cand     = OP_NONE;
    ok       = 1'b0;
    unique case (grp)
      GRP_ADDSUB: begin
        if (sz == 2'b11) begin
          cand     = is_sub ? OP_SUBA : OP_ADDA;
          ok       = src_any_ok;
          dec.size = dbit ? 2'b10 : 2'b01;
          dec.dir  = 1'b0;
        end else if (!dbit) begin
          cand = is_sub ? OP_SUB : OP_ADD;
          ok   = src_any_ok && !((word[5:3] == 3'd1) && (sz == 2'b00));
        end else if (is_sub && (word[5:4] == 2'b00)) begin
          cand = OP_SUBX;
          ok   = 1'b1;
        end else begin
          cand = is_sub ? OP_SUB : OP_ADD;
          ok   = dst_mem_ok;
        end
      end
      GRP_ANDOR: begin
        cand = is_or ? OP_OR : OP_AND;
        ok   = (sz != 2'b11) && (dbit ? dst_mem_ok : src_noar_ok);
      end
      GRP_EOR: begin
        cand = OP_EOR;
        ok   = (sz != 2'b11) && dst_dat_ok;
      end
      GRP_IMM: begin
        cand     = imm_op;
        ok       = (sz != 2'b11) && dst_dat_ok;
        dec.dir  = 1'b1;
        dec.rnum = '0;
      end
      default: begin
        cand = OP_NONE;
        ok   = 1'b0;
      end
    endcase
    dec.illegal = !ok;
    dec.op      = ok ? cand : OP_NONE;
  end
endmodule

// File: rtl/alu_opc_decoder.sv
module alu_opc_decoder
  import alu_opc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_word,
  output logic              out_valid,
  output logic [3:0]        out_op,
  output logic [1:0]        out_size,
  output logic              out_dir,
  output logic [2:0]        out_reg,
  output logic [2:0]        out_mode,
  output logic [2:0]        out_mreg,
  output logic              out_illegal
);
  dec_t comb_dec;
  dec_t held;
  logic accept;

  assign accept = in_valid && in_ready;

  alu_opc_core u_core (.word(in_word), .dec(comb_dec));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      held      <= '0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= accept;
      if (accept) held <= comb_dec;
    end
  end

  assign out_op      = held.op;
  assign out_size    = held.size;
  assign out_dir     = held.dir;
  assign out_reg     = held.rnum;
  assign out_mode    = held.mode;
  assign out_mreg    = held.mreg;
  assign out_illegal = held.illegal;

  assert_valid_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  assert_quiet_without_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_valid);
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(out_op) && $stable(out_illegal) && $stable(out_mode) && $stable(out_reg)));
  assert_illegal_means_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_op == OP_NONE));
  assert_src_mode7_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && !out_dir && (out_mode == 3'd7)) |-> (out_mreg < 3'd5));
  assert_dst_memory_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && out_dir &&
     (out_op inside {OP_ADD, OP_SUB, OP_AND, OP_OR})) |-> (out_mode > 3'd1 && !(out_mode == 3'd7 && out_mreg > 3'd1)));
  assert_logic_no_areg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && (out_op inside {OP_AND, OP_OR})) |-> (out_mode != 3'd1));
  assert_imm_to_ea_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_op inside {OP_ORI, OP_SUBI, OP_EORI})) |-> (out_dir && out_mode != 3'd1 && out_size != 2'b11));
  assert_addr_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_op inside {OP_ADDA, OP_SUBA})) |-> (!out_dir && (out_size == 2'b01 || out_size == 2'b10)));
endmodule

// File: tb/test_alu_opc_decoder.sv
module test_alu_opc_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic [3:0]  out_op;
  logic [1:0]  out_size;
  logic        out_dir;
  logic [2:0]  out_reg, out_mode, out_mreg;
  logic        out_illegal;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [16:0] last_exp = '0;

  always #2 clk = ~clk;

  alu_opc_decoder i_alu_opc_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_op(out_op),
    .out_size(out_size), .out_dir(out_dir), .out_reg(out_reg),
    .out_mode(out_mode), .out_mreg(out_mreg), .out_illegal(out_illegal)
  );

  // Expected {illegal, op, size, dir, reg, mode, mreg} from the requirement text.
  function automatic logic [16:0] model(input logic [15:0] w);
    logic [3:0] top4;
    logic [1:0] sz;
    logic       d;
    logic [2:0] r, m, q;
    logic [3:0] op;
    logic       good, bad_src, bad_dst;
    top4 = w[15:12]; sz = w[7:6]; d = w[8];
    r = w[11:9]; m = w[5:3]; q = w[2:0];
    op = 4'd0; good = 1'b0;
    bad_src = (m == 3'd7) && (q >= 3'd5);
    bad_dst = (m == 3'd7) && (q >= 3'd2);
    if (top4 == 4'hD || top4 == 4'h9) begin
      if (sz == 2'd3) begin
        op = (top4 == 4'h9) ? 4'd7 : 4'd6;
        good = !bad_src; sz = d ? 2'd2 : 2'd1; d = 1'b0;
      end else if (!d) begin
        op = (top4 == 4'h9) ? 4'd2 : 4'd1;
        good = !bad_src && !(m == 3'd1 && sz == 2'd0);
      end else if (top4 == 4'h9 && m <= 3'd1) begin
        op = 4'd8; good = 1'b1;
      end else begin
        op = (top4 == 4'h9) ? 4'd2 : 4'd1;
        good = (m >= 3'd2) && !bad_dst;
      end
    end else if (top4 == 4'hC || top4 == 4'h8) begin
      op = (top4 == 4'h8) ? 4'd4 : 4'd3;
      if (d) good = (sz != 2'd3) && (m >= 3'd2) && !bad_dst;
      else   good = (sz != 2'd3) && (m != 3'd1) && !bad_src;
    end else if (top4 == 4'hB && d) begin
      op = 4'd5; good = (sz != 2'd3) && (m != 3'd1) && !bad_dst;
    end else if (w[15:8] == 8'h00 || w[15:8] == 8'h04 || w[15:8] == 8'h0A) begin
      op = (w[15:8] == 8'h00) ? 4'd9 : (w[15:8] == 8'h04) ? 4'd10 : 4'd11;
      good = (sz != 2'd3) && (m != 3'd1) && !bad_dst;
      d = 1'b1; r = 3'd0;
    end
    if (!good) op = 4'd0;
    return {!good, op, sz, d, r, m, q};
  endfunction

  function automatic string tag_of(input logic [15:0] w);
    if ((w[15:12] == 4'hD || w[15:12] == 4'h9) && w[7:6] == 2'd3) return "R7";
    if (w[15:12] == 4'h9 && w[8] && w[5:4] == 2'd0) return "R9";
    if (w[15:8] == 8'h00 || w[15:8] == 8'h04 || w[15:8] == 8'h0A) return "R8";
    if (w[15:12] inside {4'hD, 4'h9, 4'hC, 4'h8} || (w[15:12] == 4'hB && w[8]))
      return w[8] ? "R5" : "R4";
    return "R10";
  endfunction

  function automatic logic [16:0] seen();
    return {out_illegal, out_op, out_size, out_dir, out_reg, out_mode, out_mreg};
  endfunction

  task automatic feed(input logic [15:0] w, input string tag);
    logic [16:0] exp;
    exp = model(w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    checks++;
    if (!out_valid || seen() !== exp) begin
      errors++;
      $display("FAIL %s word=%h actual v=%b %h expected v=1 %h", tag, w, out_valid, seen(), exp);
    end
    last_exp = exp;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_word  = 16'(~in_word);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || seen() !== last_exp) begin
      errors++;
      $display("FAIL R11 idle actual v=%b %h expected v=0 %h", out_valid, seen(), last_exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual cycles=%0d expected below 190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    checks++;
    if (in_ready !== 1'b0 || out_valid !== 1'b0 || out_op !== 4'd0 || out_illegal !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual rdy=%b v=%b op=%0d ill=%b expected 0 0 0 0",
               in_ready, out_valid, out_op, out_illegal);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 ready actual %b expected 1", in_ready);
    end

    // Directed corners
    feed(16'hD000, "R2");   // add.b d0,d0
    feed(16'h8A52, "R3");   // or.w (a2),d5
    feed(16'hB100, "R2");   // eor d0 -> d0, mode 0 allowed
    feed(16'hB000, "R10");  // compare family
    feed(16'hD008, "R6");   // byte add from address register
    feed(16'hD048, "R6");   // word add from address register is fine
    feed(16'hC048, "R6");   // and from address register
    feed(16'h8008, "R6");
    feed(16'hD03C, "R4");   // mode 7 reg 4 as source
    feed(16'hD03D, "R4");   // mode 7 reg 5 as source
    feed(16'hD139, "R5");   // destination absolute long
    feed(16'hD13A, "R5");   // destination pc-relative
    feed(16'hD100, "R5");   // add with bit 8 and mode 0
    feed(16'hD1C8, "R7");   // adda.l a0,a0
    feed(16'h92FD, "R7");   // suba.w with mode 7 reg 5
    feed(16'h9F4F, "R9");   // subx predecrement word
    feed(16'h9300, "R9");   // subx data regs byte
    feed(16'h0039, "R8");   // ori.b to absolute long
    feed(16'h0A7C, "R8");   // eori.w with mode 7 reg 4
    feed(16'h04C0, "R8");   // subi size 11
    feed(16'h0448, "R8");   // subi to address register
    feed(16'hC0C0, "R10");  // and size 11
    feed(16'h4E71, "R10");
    feed(16'h1234, "R10");
    idle();
    idle();

    // Random words with random idle gaps
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 4) == 0) w[15:12] = 4'h9;
      feed(w, tag_of(w));
      if (($urandom % 8) == 0) idle();
    end
    idle();

    // Exhaustive sweep, back to back
    for (int k = 0; k < 65536; k++) begin
      feed(16'(k), tag_of(16'(k)));
    end
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule